// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block decides which of several bus masters may drive a shared bus. Every master raises its own request bit, and the bits are merged into one shared request line that behaves as a wired OR. When the bus is free and that line is high, a single grant token enters the chain at device 0 and is handed down by position. A device that is requesting keeps the token. A device that is not requesting passes it to its neighbour. The first requester in chain order therefore becomes the owner.

Ownership is held until a release pulse appears on the shared release line. Requests that change while the bus is owned have no effect. After a release the bus stays idle for one cycle and is then arbitrated again among the requests pending at that point. Priority is purely positional. A device far down the chain can be starved for as long as a device nearer the start keeps asking.

Top module: `chain_bus_arbiter`

## Requirements
- R1: While reset is asserted and after it is released with no requests, every grant output and bus_busy are low.
- R2: When the bus is idle and at least one request bit is high at a clock edge, exactly one grant appears at the outputs one cycle after that edge.
- R3: Device index 0 has the highest priority and index NUM_DEV-1 the lowest. Bit i of dev_gnt is set for the lowest-indexed device whose request bit was high.
- R4: At most one bit of dev_gnt is high in any cycle.
- R5: While the bus is owned and no release bit is high, dev_gnt does not change, whatever the request inputs do.
- R6: A high bit on any dev_rel line while the bus is owned clears dev_gnt and bus_busy in the next cycle.
- R7: One cycle after the release has taken effect, the pending requests are arbitrated again and the winner is granted.
- R8: bus_busy is high exactly when some bit of dev_gnt is high.
- R9: A release pulse while the bus is idle has no effect. A later request is granted after the usual single cycle.
- R10: A low-priority request receives no grant while a higher-priority device keeps requesting across repeated release cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | NUM_DEV | Per-device bus request; bit 0 is highest priority |
| dev_rel | input | NUM_DEV | Per-device release pulse, merged onto the shared release line |
| dev_gnt | output | NUM_DEV | Per-device grant, at most one high |
| bus_busy | output | 1 | High while the bus is owned |

## Verification
The hardest case to reach from the ports is starvation across repeated handovers. This needs a high-priority device to release and request again in the same stretch while a low-priority device waits. The bench keeps device 0 requesting through several release cycles and checks after each re-arbitration that the grant returns to device 0 and never reaches the last device. It then drops device 0's request so that the waiting device is granted. No-preemption is reached by raising a higher-priority request while a lower device owns the bus.

// File: rtl/chain_arb_pkg.sv
package chain_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GRANTED = 2'd1,
        ST_RELEASE = 2'd2
    } arb_state_e;

endpackage

// File: rtl/shared_line_or.sv
// Merges a vector of per-device drivers into one shared line (wired OR model).
module shared_line_or #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] drv_in,
    output logic             line_out
);
    logic [WIDTH:0] acc;

    assign acc[0] = 1'b0;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_or
        assign acc[gi+1] = acc[gi] | drv_in[gi];
    end

    assign line_out = acc[WIDTH];
endmodule

// File: rtl/grant_ripple.sv
// Positional grant chain: each stage keeps the token if requesting, else passes it on.
module grant_ripple #(
    parameter int NUM_DEV = 4
) (
    input  logic               token_in,
    input  logic [NUM_DEV-1:0] req_in,
    output logic [NUM_DEV-1:0] take_out,
    output logic               token_out
);
    logic [NUM_DEV:0] token_chain;

    assign token_chain[0] = token_in;

    for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_stage
        assign take_out[gi]      = token_chain[gi] & req_in[gi];
        assign token_chain[gi+1] = token_chain[gi] & ~req_in[gi];
    end

    assign token_out = token_chain[NUM_DEV];

    // R3: a taking stage must be requesting, and no more than one stage takes
    always_comb begin
        if (!$isunknown({token_in, req_in})) begin
            p_single_take_r3: assert ($onehot0(take_out));
            p_take_needs_req_r3: assert ((take_out & ~req_in) == '0);
        end
    end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import chain_arb_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_line,
    input  logic               rel_line,
    input  logic [NUM_DEV-1:0] winner,
    output logic               token_en,
    output logic [NUM_DEV-1:0] gnt,
    output logic               busy
);
    typedef struct packed {
        arb_state_e         state;
        logic [NUM_DEV-1:0] owner;
    } fsm_regs_t;

    fsm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_IDLE, ST_RELEASE: begin
                if (req_line) begin
                    regs_d.state = ST_GRANTED;
                    regs_d.owner = winner;
                end else begin
                    regs_d.state = ST_IDLE;
                    regs_d.owner = '0;
                end
            end
            ST_GRANTED: begin
                if (rel_line) begin
                    regs_d.state = ST_RELEASE;
                    regs_d.owner = '0;
                end
            end
            default: begin
                regs_d.state = ST_IDLE;
                regs_d.owner = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_IDLE;
            regs_q.owner <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign token_en = (regs_q.state != ST_GRANTED);
    assign gnt      = regs_q.owner;
    assign busy     = (regs_q.state == ST_GRANTED);

    p_grant_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_line) |=> busy);

    p_no_preempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rel_line) |=> (busy && $stable(gnt)));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rel_line) |=> (!busy && gnt == '0));

    p_rearb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_RELEASE && req_line) |=> busy);

    p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_line) |=> !busy);
endmodule

// File: rtl/chain_bus_arbiter.sv
module chain_bus_arbiter #(
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DEV-1:0] dev_req,
    input  logic [NUM_DEV-1:0] dev_rel,
    output logic [NUM_DEV-1:0] dev_gnt,
    output logic               bus_busy
);
    logic               req_line;
    logic               rel_line;
    logic               token_en;
    logic               token_left;
    logic [NUM_DEV-1:0] winner;

    shared_line_or #(.WIDTH(NUM_DEV)) u_req_or (
        .drv_in   (dev_req),
        .line_out (req_line)
    );

    shared_line_or #(.WIDTH(NUM_DEV)) u_rel_or (
        .drv_in   (dev_rel),
        .line_out (rel_line)
    );

    grant_ripple #(.NUM_DEV(NUM_DEV)) u_ripple (
        .token_in  (token_en),
        .req_in    (dev_req),
        .take_out  (winner),
        .token_out (token_left)
    );

    arb_fsm #(.NUM_DEV(NUM_DEV)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_line (req_line),
        .rel_line (rel_line),
        .winner   (winner),
        .token_en (token_en),
        .gnt      (dev_gnt),
        .busy     (bus_busy)
    );

    // the token leaves the chain only when nobody requests
    p_token_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (token_en && token_left) |-> !req_line);

    p_onehot_gnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_gnt));

    p_busy_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy == (dev_gnt != '0));

    p_owner_requested_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> ((dev_gnt & ~$past(dev_req)) == '0));
endmodule

// File: tb/chain_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module chain_bus_arbiter_tb_top;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] dev_req = '0;
    logic [N-1:0] dev_rel = '0;
    logic [N-1:0] dev_gnt;
    logic         bus_busy;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    chain_bus_arbiter #(.NUM_DEV(N)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_req  (dev_req),
        .dev_rel  (dev_rel),
        .dev_gnt  (dev_gnt),
        .bus_busy (bus_busy)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [N-1:0] got_g, input logic [N-1:0] exp_g,
                       input logic got_b, input logic exp_b);
        total++;
        if (got_g !== exp_g || got_b !== exp_b) begin
            bad++;
            $display("FAIL %s: gnt=%b busy=%b expected gnt=%b busy=%b", tag, got_g, got_b, exp_g, exp_b);
        end
    endtask

    task automatic pulse_release(input int idx);
        dev_rel = '0;
        dev_rel[idx] = 1'b1;
        tick();
        dev_rel = '0;
    endtask

    task automatic t_reset();
        chk("R1 in reset", dev_gnt, '0, bus_busy, 1'b0);
        rst_n = 1'b1;
        tick();
        tick();
        chk("R1 after reset", dev_gnt, '0, bus_busy, 1'b0);
    endtask

    task automatic t_single();
        dev_req = 5'b00100;
        tick();
        chk("R2 single grant dev2", dev_gnt, 5'b00100, bus_busy, 1'b1);
        chk("R8 busy with grant", dev_gnt, 5'b00100, bus_busy, 1'b1);
        pulse_release(2);
        dev_req = '0;
        chk("R6 release clears", dev_gnt, '0, bus_busy, 1'b0);
        tick();
        chk("R8 idle after release", dev_gnt, '0, bus_busy, 1'b0);
    endtask

    task automatic t_priority();
        dev_req = 5'b11010;
        tick();
        chk("R3 lowest index wins", dev_gnt, 5'b00010, bus_busy, 1'b1);
        total++;
        if ($countones(dev_gnt) > 1) begin
            bad++;
            $display("FAIL R4: gnt=%b expected at most one bit", dev_gnt);
        end
        pulse_release(1);
        dev_req = '0;
        tick();
        chk("R3 cleanup idle", dev_gnt, '0, bus_busy, 1'b0);
    endtask

    task automatic t_no_preempt();
        dev_req = 5'b01000;
        tick();
        chk("R2 grant dev3", dev_gnt, 5'b01000, bus_busy, 1'b1);
        dev_req = 5'b01001;
        tick();
        chk("R5 hold with higher req", dev_gnt, 5'b01000, bus_busy, 1'b1);
        dev_req = 5'b00001;
        tick();
        tick();
        chk("R5 hold after owner drops req", dev_gnt, 5'b01000, bus_busy, 1'b1);
        pulse_release(3);
        chk("R6 gap after release", dev_gnt, '0, bus_busy, 1'b0);
        tick();
        chk("R7 rearbitrate to dev0", dev_gnt, 5'b00001, bus_busy, 1'b1);
        pulse_release(0);
        dev_req = '0;
        tick();
        chk("R7 idle when none pending", dev_gnt, '0, bus_busy, 1'b0);
    endtask

    task automatic t_idle_release();
        pulse_release(4);
        chk("R9 idle release no grant", dev_gnt, '0, bus_busy, 1'b0);
        tick();
        chk("R9 still idle", dev_gnt, '0, bus_busy, 1'b0);
        dev_req = 5'b10000;
        tick();
        chk("R9 next request one cycle", dev_gnt, 5'b10000, bus_busy, 1'b1);
        pulse_release(4);
        dev_req = '0;
        tick();
    endtask

    task automatic t_starve();
        dev_req = 5'b10001;
        tick();
        chk("R10 first grant dev0", dev_gnt, 5'b00001, bus_busy, 1'b1);
        for (int k = 0; k < 4; k++) begin
            pulse_release(0);
            tick();
            chk("R10 dev0 regains bus", dev_gnt, 5'b00001, bus_busy, 1'b1);
        end
        dev_req = 5'b10000;
        pulse_release(0);
        tick();
        chk("R10 starved dev4 finally granted", dev_gnt, 5'b10000, bus_busy, 1'b1);
        pulse_release(4);
        dev_req = '0;
        tick();
    endtask

    initial begin
        #1;
        t_reset();
        t_single();
        t_priority();
        t_no_preempt();
        t_idle_release();
        t_starve();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule